// File: doc/BRIEF.md
# B1 Section Parity Checker and Error Counter

This block checks the section-level BIP-8 of a received SONET stream. It folds every byte of a frame into an 8-bit even-parity word using the data exactly as it arrives on the line, before descrambling. The framing and trace bytes go into this word as well, even though they are not scrambled. When the next frame starts, the finished word becomes the reference. The B1 byte of that next frame is then compared with it.

The receive side presents one byte per valid cycle. With each byte it gives a strobe that marks the first byte of a frame and the byte offset inside the frame. A mode input selects one-column (STS-1) or three-column (STS-3) frames, and this moves the place where B1 is read. A configuration input selects how mismatches are counted: each differing bit (0 to 8 per frame), or each frame that has any difference (0 or 1). Errors add up in a running counter. A performance-monitor strobe copies the running value into a 16-bit holding register and restarts the count. Both actions happen in one clock, so the count loses no error.

Top module: `b1_bip8_monitor`

## Requirements
- R1: With `cnt_block`=0, each checked frame yields `chk_errs` equal to the number of bits in which the received B1 differs from the even parity (bitwise XOR) of every valid byte of the previous frame. That parity runs from the byte with `in_sof`=1 up to the byte before the next `in_sof`, and it includes the framing bytes and the B1 byte itself.
- R2: With `cnt_block`=1, each checked frame yields `chk_errs`=1 if any bit differs and 0 if none does.
- R3: No comparison is made in the first frame after reset, because no complete earlier frame exists. The first check happens in the frame that starts with the second `in_sof`.
- R4: B1 is read only at byte offset 90 when `mode_sts3`=0, and only at offset 270 when `mode_sts3`=1. A byte at the other mode's offset is not compared.
- R5: When `pm_strobe` is high on a clock, `b1_count` takes the errors accumulated since the previous strobe, and the running count starts again from zero.
- R6: If a B1 comparison and `pm_strobe` fall on the same clock, that comparison's errors are counted in the new interval and are not included in the value moved to `b1_count`.
- R7: The running count saturates at 0xFFFF and does not wrap.
- R8: After reset, `b1_count` is 0 and `chk_valid` is 0.
- R9: When `in_valid` is 0, the values on `in_data`, `in_sof` and `in_pos` are ignored.
- R10: `chk_valid` pulses for exactly one cycle, on the clock after the B1 byte is accepted. `chk_errs` is 0 whenever `chk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_data | input | 8 | Received byte, still scrambled |
| in_sof | input | 1 | First byte of a frame |
| in_pos | input | 12 | Byte offset inside the frame |
| mode_sts3 | input | 1 | 1 selects three-column frames, 0 selects one-column |
| cnt_block | input | 1 | 1 counts errored frames, 0 counts errored bits |
| pm_strobe | input | 1 | Moves the running count to the holding register and clears it |
| chk_valid | output | 1 | A B1 comparison result is present |
| chk_errs | output | 4 | Errors found by this comparison |
| b1_count | output | 16 | Error count of the last closed interval |

## Verification
The comparison result appears on `chk_valid` and `chk_errs` one clock after the B1 byte is sampled. `b1_count` shows the closed interval one clock after `pm_strobe` is sampled. The driver changes inputs on the falling edge and pushes each expected result into a queue when it presents the B1 byte. The monitor pops that result on the next falling edge, when `chk_valid` is due. A pulse with nothing queued, or an entry left in the queue at the end, counts as a failure. Holding-register values are read on the falling edge right after the strobe's rising edge. This also holds for the case where the strobe falls on the B1 byte.

// File: rtl/b1_bip8_pkg.sv
package b1_bip8_pkg;

    localparam int BIP_W = 8;
    localparam int ERR_W = $clog2(BIP_W + 1);

    typedef struct packed {
        logic [BIP_W-1:0] run_par;
        logic [BIP_W-1:0] ref_par;
        logic             ref_ok;
        logic             aligned;
    } par_state_t;

    typedef struct packed {
        logic             valid;
        logic [ERR_W-1:0] errs;
    } cmp_state_t;

    function automatic logic [ERR_W-1:0] ones_in(input logic [BIP_W-1:0] v);
        logic [ERR_W-1:0] n;
        n = '0;
        for (int i = 0; i < BIP_W; i++) begin
            n = n + ERR_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/b1_parity_acc.sv
module b1_parity_acc
    import b1_bip8_pkg::*;
#(
    parameter int ROW_BYTES = 90,
    parameter int POS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic [POS_W-1:0] in_pos,
    input  logic             mode_sts3,
    output logic             b1_hit,
    output logic [BIP_W-1:0] b1_data,
    output logic [BIP_W-1:0] ref_par
);

    localparam int B1_OFF_ONE   = ROW_BYTES;
    localparam int B1_OFF_THREE = 3 * ROW_BYTES;

    par_state_t       st_d, st_q;
    logic [POS_W-1:0] b1_pos;

    always_comb begin
        b1_pos = mode_sts3 ? POS_W'(B1_OFF_THREE) : POS_W'(B1_OFF_ONE);
    end

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (in_sof) begin
                st_d.ref_par = st_q.run_par;
                st_d.ref_ok  = st_q.aligned;
                st_d.aligned = 1'b1;
                st_d.run_par = in_data;
            end else begin
                st_d.run_par = st_q.run_par ^ in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        b1_hit  = in_valid && !in_sof && (in_pos == b1_pos) && st_q.ref_ok;
        b1_data = in_data;
        ref_par = st_q.ref_par;
    end

endmodule

// File: rtl/b1_compare.sv
module b1_compare
    import b1_bip8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             b1_hit,
    input  logic [BIP_W-1:0] b1_data,
    input  logic [BIP_W-1:0] ref_par,
    input  logic             cnt_block,
    output logic [ERR_W-1:0] inc_val,
    output logic             chk_valid,
    output logic [ERR_W-1:0] chk_errs
);

    cmp_state_t       st_d, st_q;
    logic [BIP_W-1:0] diff;
    logic [ERR_W-1:0] n_err;

    always_comb begin
        diff  = b1_data ^ ref_par;
        n_err = cnt_block ? ERR_W'(|diff) : ones_in(diff);
        inc_val = b1_hit ? n_err : '0;
        st_d.valid = b1_hit;
        st_d.errs  = inc_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        chk_valid = st_q.valid;
        chk_errs  = st_q.errs;
    end

endmodule

// File: rtl/b1_err_counter.sv
module b1_err_counter
    import b1_bip8_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] inc_val,
    input  logic             pm_strobe,
    output logic [CNT_W-1:0] hold
);

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] hold;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d = st_q;
        base = pm_strobe ? '0 : st_q.run;
        sum  = {1'b0, base} + (CNT_W + 1)'(inc_val);
        st_d.run = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        if (pm_strobe) begin
            st_d.hold = st_q.run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hold = st_q.hold;
    end

endmodule

// File: rtl/b1_bip8_monitor.sv
module b1_bip8_monitor
    import b1_bip8_pkg::*;
#(
    parameter int ROW_BYTES = 90,
    parameter int ROWS      = 9,
    parameter int CNT_W     = 16,
    localparam int FRAME_MAX = 3 * ROW_BYTES * ROWS,
    localparam int POS_W     = $clog2(FRAME_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic [POS_W-1:0] in_pos,
    input  logic             mode_sts3,
    input  logic             cnt_block,
    input  logic             pm_strobe,
    output logic             chk_valid,
    output logic [ERR_W-1:0] chk_errs,
    output logic [CNT_W-1:0] b1_count
);

    logic             b1_hit;
    logic [BIP_W-1:0] b1_data;
    logic [BIP_W-1:0] ref_par;
    logic [ERR_W-1:0] inc_val;

    b1_parity_acc #(
        .ROW_BYTES (ROW_BYTES),
        .POS_W     (POS_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_pos    (in_pos),
        .mode_sts3 (mode_sts3),
        .b1_hit    (b1_hit),
        .b1_data   (b1_data),
        .ref_par   (ref_par)
    );

    b1_compare u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .b1_hit    (b1_hit),
        .b1_data   (b1_data),
        .ref_par   (ref_par),
        .cnt_block (cnt_block),
        .inc_val   (inc_val),
        .chk_valid (chk_valid),
        .chk_errs  (chk_errs)
    );

    b1_err_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_val   (inc_val),
        .pm_strobe (pm_strobe),
        .hold      (b1_count)
    );

endmodule

// File: rtl/b1_bip8_monitor_chk.sv
module b1_bip8_monitor_chk
    import b1_bip8_pkg::*;
#(
    parameter int ROW_BYTES = 90,
    parameter int POS_W     = 12,
    parameter int CNT_W     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic [POS_W-1:0] in_pos,
    input logic             mode_sts3,
    input logic             cnt_block,
    input logic             pm_strobe,
    input logic             chk_valid,
    input logic [ERR_W-1:0] chk_errs,
    input logic [CNT_W-1:0] b1_count
);

    logic [1:0]       sof_seen;
    logic [POS_W-1:0] b1_pos;

    always_comb begin
        b1_pos = mode_sts3 ? POS_W'(3 * ROW_BYTES) : POS_W'(ROW_BYTES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof_seen <= '0;
        end else if (in_valid && in_sof && sof_seen != 2'd2) begin
            sof_seen <= sof_seen + 2'd1;
        end
    end

    // R10: a result only follows an accepted byte at the B1 offset
    a_r10_after_b1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> ($past(in_valid) && !$past(in_sof) && $past(in_pos) == $past(b1_pos)));

    // R10: no error value without a result
    a_r10_quiet_errs: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> chk_errs == '0);

    // R3: no result before a full earlier frame
    a_r3_no_early_check: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> sof_seen == 2'd2);

    // R1: at most one error per parity bit
    a_r1_errs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> chk_errs <= ERR_W'(BIP_W));

    // R2: block mode reports at most one error
    a_r2_block_single: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && $past(cnt_block)) |-> chk_errs <= ERR_W'(1));

    // R5: the holding register changes only on the strobe
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_strobe |=> $stable(b1_count));

endmodule

bind b1_bip8_monitor b1_bip8_monitor_chk #(
    .ROW_BYTES (ROW_BYTES),
    .POS_W     (POS_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_pos    (in_pos),
    .mode_sts3 (mode_sts3),
    .cnt_block (cnt_block),
    .pm_strobe (pm_strobe),
    .chk_valid (chk_valid),
    .chk_errs  (chk_errs),
    .b1_count  (b1_count)
);

// File: tb/b1_bip8_monitor_test.sv
module b1_bip8_monitor_test;

    localparam int ROW   = 90;
    localparam int POS_W = 12;
    localparam int CNT_W = 16;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_sof = 1'b0;
    logic [POS_W-1:0] in_pos = '0;
    logic             mode_sts3 = 1'b0;
    logic             cnt_block = 1'b0;
    logic             pm_strobe = 1'b0;
    logic             chk_valid;
    logic [3:0]       chk_errs;
    logic [CNT_W-1:0] b1_count;

    int         n_chk = 0;
    int         n_fail = 0;
    int         exp_q[$];
    string      tag_q[$];
    logic [7:0] cur_par = '0;
    logic [7:0] prev_par_m = '0;
    bit         have_prev_m = 0;
    int         run_m = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    b1_bip8_monitor uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_pos    (in_pos),
        .mode_sts3 (mode_sts3),
        .cnt_block (cnt_block),
        .pm_strobe (pm_strobe),
        .chk_valid (chk_valid),
        .chk_errs  (chk_errs),
        .b1_count  (b1_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    // R9: idle cycles carry junk that must be ignored
    task automatic idle_junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_data   = 8'($urandom);
            in_sof    = 1'b1;
            in_pos    = mode_sts3 ? POS_W'(3 * ROW) : POS_W'(ROW);
            pm_strobe = 1'b0;
        end
    endtask

    task automatic emit(input int p, input int b1p, input logic [7:0] mask, input bit pm);
        logic [7:0] d;
        int e;
        d = 8'($urandom);
        if (p == b1p) d = prev_par_m ^ mask;
        cur_par = cur_par ^ d;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_pos    = POS_W'(p);
        in_sof    = (p == 0);
        pm_strobe = pm && (p == b1p);
        if (p == b1p) begin
            e = cnt_block ? int'(mask != 0) : $countones(mask);
            if (have_prev_m) begin
                exp_q.push_back(e);
                tag_q.push_back(cnt_block ? "R2" : "R1");
            end
            if (pm) begin
                int hold_exp;
                hold_exp = run_m;
                run_m = have_prev_m ? e : 0;
                @(negedge clk);
                in_valid  = 1'b0;
                pm_strobe = 1'b0;
                check(b1_count == CNT_W'(hold_exp), "R6", int'(b1_count), hold_exp);
            end else if (have_prev_m) begin
                run_m = sat(run_m + e);
            end
        end
    endtask

    // kind 0: two bytes, 1: short with junk and other-mode offset, 2: full frame
    task automatic send_frame(input int kind, input logic [7:0] mask, input bit pm);
        int b1p, other, len;
        b1p   = mode_sts3 ? 3 * ROW : ROW;
        other = mode_sts3 ? ROW : 3 * ROW;
        len   = mode_sts3 ? 27 * ROW : 9 * ROW;
        cur_par = '0;
        if (kind == 2) begin
            for (int p = 0; p < len; p++) emit(p, b1p, mask, pm);
        end else if (kind == 1) begin
            emit(0, b1p, mask, pm);
            emit(1, b1p, mask, pm);
            idle_junk(1);
            emit(other, b1p, mask, pm);   // R4: other mode's offset is not compared
            emit(b1p, b1p, mask, pm);
            idle_junk(1);
            emit(b1p + 1, b1p, mask, pm);
        end else begin
            emit(0, b1p, mask, pm);
            emit(b1p, b1p, mask, pm);
        end
        prev_par_m  = cur_par;
        have_prev_m = 1;
    endtask

    task automatic pm_check(input string req);
        int exp;
        @(negedge clk);
        in_valid  = 1'b0;
        pm_strobe = 1'b1;
        exp = run_m;
        run_m = 0;
        @(negedge clk);
        pm_strobe = 1'b0;
        check(b1_count == CNT_W'(exp), req, int'(b1_count), exp);
        check(!chk_valid && chk_errs == 4'd0, "R10", int'(chk_errs), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && chk_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R3/R4 unexpected check actual=%0d expected=none", chk_errs);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(chk_errs == 4'(e), t, int'(chk_errs), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(b1_count == '0, "R8", int'(b1_count), 0);
        check(chk_valid == 1'b0, "R8", int'(chk_valid), 0);
        rst_n = 1'b1;

        // R3: first frame after reset is not checked
        mode_sts3 = 1'b0;
        cnt_block = 1'b0;
        send_frame(1, 8'hFF, 0);
        // R1: full one-column frames, bit counting
        send_frame(2, 8'h00, 0);
        send_frame(2, 8'h05, 0);
        send_frame(1, 8'h80, 0);
        pm_check("R5");
        pm_check("R5");

        // R2: block counting
        cnt_block = 1'b1;
        send_frame(1, 8'h0F, 0);
        send_frame(1, 8'h00, 0);
        send_frame(1, 8'hFF, 0);
        pm_check("R2");

        // R4: three-column frames, B1 at offset 270
        cnt_block = 1'b0;
        mode_sts3 = 1'b1;
        send_frame(2, 8'h11, 0);
        send_frame(2, 8'h00, 0);
        send_frame(1, 8'hA0, 0);
        pm_check("R4");

        // R6: strobe on the B1 clock
        send_frame(1, 8'h03, 0);
        send_frame(1, 8'h07, 1);
        pm_check("R6");

        // R7: saturation of the running count
        mode_sts3 = 1'b0;
        for (int k = 0; k < 8200; k++) send_frame(0, 8'hFF, 0);
        idle_junk(2);
        pm_check("R7");
        pm_check("R7");

        idle_junk(3);
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule